// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind a two-wire serial slave in a small byte-addressed non-volatile memory. It takes the word address that opens a write transaction and then one byte per strobe, and keeps those bytes in a page buffer. Each new byte goes to the next location of the current page. When the bus Stop arrives, the block plays the buffered bytes into the memory array as a sequence of single-byte write strobes. It then stays busy for a programmable number of clocks, which models the self-timed program cycle.

While busy is high, the slave is expected to withhold its acknowledges, and the block ignores everything offered to it. A write-protect input covers the whole array. Under protection, bytes are still taken in, but a Stop discards them. No write strobes and no busy period follow.

Top module: `page_commit_seq`

## Requirements
- R1: After reset, `busy_o` and `arr_we_o` are low and the page buffer holds no pending bytes.
- R2: A byte accepted by `byte_vld_i` goes to array address {upper address bits latched by `addr_load_i`, current 4-bit offset}. Only the 4-bit offset (address bits 3:0) advances after each byte, wrapping from 15 to 0, so the data stays inside the 16-byte page and address bits 8:4 never change.
- R3: When more than 16 bytes arrive before Stop, a later byte replaces the earlier byte at the same offset, and the array receives only the latest value.
- R4: `arr_we_o` is never high while `busy_o` is low. In particular, no array write happens before Stop.
- R5: Only offsets written since the last `addr_load_i` are committed. Exactly one array write is issued per written offset.
- R6: A Stop with `wp_i` high produces no array write and no busy period, and it discards the buffered bytes.
- R7: A Stop with pending bytes and `wp_i` low raises `busy_o` on the next clock. `busy_o` then stays high for exactly WCYCLE_CLKS clocks.
- R8: While `busy_o` is high, `addr_load_i`, `byte_vld_i` and `stop_i` have no effect. Bytes offered during busy are never committed.
- R9: A Stop with no pending bytes produces no array write and no busy period.
- R10: Commit writes are issued one per clock in the first 16 clocks of busy, in ascending offset order (0 to 15), with skipped offsets left out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load_i | input | 1 | Latch starting word address and clear pending bytes |
| addr_i | input | 9 | Starting word address |
| byte_vld_i | input | 1 | One data byte offered |
| byte_i | input | 8 | Data byte |
| stop_i | input | 1 | Bus Stop event |
| wp_i | input | 1 | Whole-array write protect |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 9 | Array write address |
| arr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Self-timed write cycle in progress |

## Verification
The bench keeps the default 9-bit address and 16-byte page, so the top page at 0x1F0 and the offset wrap are both reached. It sets WCYCLE_CLKS to 24 instead of the long default. This keeps each busy period short, so the exact busy length and the offers made during busy can be checked in many scenarios. With a value of 24, the busy window is still longer than the 16 commit slots, so the idle tail after the last write is also covered.

// File: rtl/page_commit_seq.sv
module page_commit_seq #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int WCYCLE_CLKS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(WCYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WCYCLE_CLKS - 1);
  localparam logic [CNT_W-1:0] WIN_CNT  = CNT_W'(PAGE_BYTES);

  logic [PG_W-1:0]       page_q;
  logic [OFS_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [DATA_W-1:0]     buf_q [PAGE_BYTES];
  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [OFS_W-1:0]      slot;

  assign slot       = cnt_q[OFS_W-1:0];
  assign arr_we_o   = busy_q && (cnt_q < WIN_CNT) && mask_q[slot];
  assign arr_addr_o = {page_q, slot};
  assign arr_data_o = buf_q[slot];
  assign busy_o     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST_CNT) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        mask_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (stop_i) begin
      if (mask_q != '0 && !wp_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        mask_q <= '0;
      end
    end else if (addr_load_i) begin
      page_q <= addr_i[ADDR_W-1:OFS_W];
      ptr_q  <= addr_i[OFS_W-1:0];
      mask_q <= '0;
    end else if (byte_vld_i) begin
      buf_q[ptr_q]  <= byte_i;
      mask_q[ptr_q] <= 1'b1;
      ptr_q         <= ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/page_commit_seq_chk.sv
module page_commit_seq_chk #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int WCYCLE_CLKS = 2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              wp_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              busy_o
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WCYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WCYCLE_CLKS - 1);

  logic [CNT_W-1:0] bcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy_o) bcnt <= '0;
    else bcnt <= bcnt + 1'b1;
  end

  assert_we_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !arr_we_o);
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && bcnt < LAST_CNT |=> busy_o);
  assert_busy_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && bcnt == LAST_CNT |=> !busy_o);
  assert_wp_no_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && stop_i && wp_i |=> !busy_o);
  assert_same_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o[ADDR_W-1:OFS_W] == $past(arr_addr_o[ADDR_W-1:OFS_W]));
  assert_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o && $past(arr_we_o) |-> arr_addr_o[OFS_W-1:0] > $past(arr_addr_o[OFS_W-1:0]));
endmodule

bind page_commit_seq page_commit_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WCYCLE_CLKS(WCYCLE_CLKS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .wp_i(wp_i),
  .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .busy_o(busy_o)
);

// File: tb/page_commit_seq_tb_top.sv
`timescale 1ns/1ps
module page_commit_seq_tb_top;
  localparam int W = 24;
  logic clk = 0, rst_n = 0;
  logic addr_load_i = 0, byte_vld_i = 0, stop_i = 0, wp_i = 0;
  logic [8:0] addr_i = '0;
  logic [7:0] byte_i = '0;
  logic arr_we_o, busy_o;
  logic [8:0] arr_addr_o;
  logic [7:0] arr_data_o;

  page_commit_seq #(.WCYCLE_CLKS(W)) dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cap_n = 0, busy_cnt = 0;
  logic [8:0] cap_addr [64];
  logic [7:0] cap_data [64];

  always @(negedge clk) begin
    if (arr_we_o && cap_n < 64) begin
      cap_addr[cap_n] = arr_addr_o;
      cap_data[cap_n] = arr_data_o;
    end
    if (arr_we_o) cap_n++;
    if (busy_o) busy_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_cap();
    @(posedge clk);
    cap_n = 0; busy_cnt = 0;
    @(negedge clk);
  endtask

  task automatic do_load(logic [8:0] a);
    addr_load_i = 1; addr_i = a;
    @(negedge clk); addr_load_i = 0;
  endtask

  task automatic do_byte(logic [7:0] b);
    byte_vld_i = 1; byte_i = b;
    @(negedge clk); byte_vld_i = 0;
  endtask

  task automatic do_stop(logic wp);
    stop_i = 1; wp_i = wp;
    @(negedge clk); stop_i = 0; wp_i = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < W + 4; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 we", arr_we_o, 0);
    clear_cap();
    do_stop(0);
    wait_idle();
    chk("R1 nothing pending", busy_cnt, 0);
  endtask

  task automatic t_single();
    clear_cap();
    do_load(9'h123);
    do_byte(8'hA5);
    chk("R4 no write before stop", cap_n, 0);
    do_stop(0);
    chk("R7 busy after stop", busy_o, 1);
    wait_idle();
    chk("R5 one write", cap_n, 1);
    chk("R2 addr", cap_addr[0], 9'h123);
    chk("R2 data", cap_data[0], 8'hA5);
    chk("R7 busy length", busy_cnt, W);
  endtask

  task automatic t_wrap();
    logic [8:0] ea [6] = '{9'h1F0, 9'h1F1, 9'h1FC, 9'h1FD, 9'h1FE, 9'h1FF};
    logic [7:0] ed [6] = '{8'h14, 8'h15, 8'h10, 8'h11, 8'h12, 8'h13};
    clear_cap();
    do_load(9'h1FC);
    for (int i = 0; i < 6; i++) do_byte(8'h10 + 8'(i));
    do_stop(0);
    wait_idle();
    chk("R5 wrap count", cap_n, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R10 R2 wrap addr order", cap_addr[i], ea[i]);
      chk("R2 wrap data", cap_data[i], ed[i]);
    end
  endtask

  task automatic t_overflow();
    clear_cap();
    do_load(9'h040);
    for (int i = 0; i < 18; i++) do_byte(8'(i));
    do_stop(0);
    wait_idle();
    chk("R3 count", cap_n, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R3 addr", cap_addr[i], 9'h040 + 9'(i));
      chk("R3 data", cap_data[i], (i < 2) ? i + 16 : i);
    end
  endtask

  task automatic t_sparse();
    clear_cap();
    do_load(9'h0A3);
    do_byte(8'h5A);
    do_load(9'h0A7);
    do_byte(8'hC3);
    do_byte(8'h3C);
    do_stop(0);
    wait_idle();
    chk("R5 sparse count", cap_n, 2);
    chk("R5 sparse addr0", cap_addr[0], 9'h0A7);
    chk("R5 sparse addr1", cap_addr[1], 9'h0A8);
    chk("R5 sparse data1", cap_data[1], 8'h3C);
  endtask

  task automatic t_wp();
    clear_cap();
    do_load(9'h000);
    do_byte(8'h11);
    do_byte(8'h22);
    do_stop(1);
    chk("R6 no busy", busy_o, 0);
    wait_idle();
    do_stop(0);
    wait_idle();
    chk("R6 no writes", cap_n, 0);
    chk("R6 R9 no busy period", busy_cnt, 0);
  endtask

  task automatic t_empty();
    clear_cap();
    do_load(9'h155);
    do_stop(0);
    wait_idle();
    chk("R9 no writes", cap_n, 0);
    chk("R9 no busy", busy_cnt, 0);
  endtask

  task automatic t_ignore();
    clear_cap();
    do_load(9'h0F0);
    do_byte(8'h77);
    do_stop(0);
    do_load(9'h033);
    do_byte(8'h99);
    do_byte(8'h98);
    do_stop(0);
    wait_idle();
    chk("R8 first commit only", cap_n, 1);
    chk("R8 addr", cap_addr[0], 9'h0F0);
    chk("R8 busy not restarted", busy_cnt, W);
    clear_cap();
    do_stop(0);
    wait_idle();
    chk("R8 busy offers dropped", cap_n, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overflow();
    t_sparse();
    t_wp();
    t_empty();
    t_ignore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule